// File: doc/BRIEF.md
# Module clock control agent

This block manages the mandatory clocks of a single hardware module. Software writes a 32-bit control word that selects the module mode and holds several clock-configuration fields. The block answers with a read-back of the same word, in which the hardware fills in the module's idle and standby status.

From the selected mode, the block derives three things:
- the interface clock enable and the functional clock enable;
- an idle request to the module, which it completes through an acknowledge handshake;
- a sleep permit to the enclosing power domain.

The idle request can be raised in two ways: by selecting the disabled mode, or, while enabled, by a sleep request from the clock domain. An asynchronous wakeup request, synchronised inside the block, withdraws the idle request. When this happens during the transition, it aborts a sleep that has not yet completed. A bus access that reaches the module while it is fully disabled is flagged as an error, unless that access comes from an asynchronous wakeup. The divider-select and clock-select fields are only stored and read back; no divider or clock multiplexer is built here.

Top module: `clkctl_agent`

## Requirements
- R1: After reset, `reg_rdata` reads 0x52580002: mode field (bits 1:0) = 2, idle status (bits 17:16) = 0, standby (bit 18) = 0, optional clock enable (bit 19) = 1, and the stored fields at bits 30:20 hold their defaults.
- R2: Writes store bits 30:19 and 1:0 and return them on read. Bits 31 and 15:2 always read 0, whatever was written.
- R3: Mode field value 0 selects disabled and value 2 selects enabled. Writing 1 or 3 stores the value and reads it back, but leaves the clock behaviour and the idle status unchanged.
- R4: The idle status encodes 0 = functional, 1 = transition, 2 = interface idle, 3 = disabled. A write that changes the effective mode shows status 1 after the second clock edge counted from the edge that takes the write.
- R5: Selecting disabled raises `idle_req`. While the status is 1, a high `mod_idle_ack` moves it to 3 at the next edge. Status 3 turns off `iclk_en`, `fclk_en` and `optfclk_en`, and raises `sleep_permit`.
- R6: Selecting enabled from status 3 drops `idle_req` and moves the status to 1. The status stays at 1 until `mod_idle_ack` falls, then moves to 0 at the next edge with all clocks on. The status never passes directly from 2 or 3 to 0.
- R7: While enabled, a high `dom_sleep_req` raises `idle_req`. With acknowledge, the status goes 0, then 1, then 2. Status 2 has `iclk_en` = 0 and `fclk_en` = 1. `sleep_permit` is 0 whenever the effective mode is enabled.
- R8: `mod_wakeup_async` takes effect after SYNC_STAGES clock edges and withdraws `idle_req`. From status 2 the status then goes to 1, and to 0 once the acknowledge falls.
- R9: A wakeup that arrives while the status is 1 and the acknowledge is still low returns the status to 0 at the next edge after it takes effect, without visiting 2 or 3.
- R10: `bus_err` is high, in the same cycle, exactly when `bus_access` is high, the status is 3 and `bus_from_wakeup` is low.
- R11: Bit 18 shows `mod_standby` one clock edge after it is sampled.
- R12: `optfclk_en` equals bit 19 of the stored word, but is forced to 0 while the status is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word with status fields |
| mod_idle_ack | input | 1 | Module acknowledges the idle request |
| mod_standby | input | 1 | Module reports standby |
| mod_wakeup_async | input | 1 | Asynchronous wakeup request from the module |
| dom_sleep_req | input | 1 | Clock domain asks the module to sleep |
| bus_access | input | 1 | A bus access targets the module |
| bus_from_wakeup | input | 1 | That access results from an asynchronous wakeup |
| iclk_en | output | 1 | Interface clock enable |
| fclk_en | output | 1 | Functional clock enable |
| optfclk_en | output | 1 | Optional functional clock enable |
| idle_req | output | 1 | Idle request to the module |
| bus_err | output | 1 | Access error while disabled |
| sleep_permit | output | 1 | Power domain may enter sleep |

## Verification
The bench builds the block with SYNC_STAGES = 2, so the wakeup latency is two edges. This short latency lets the abort case be reached by raising the wakeup one cycle after the status first reads 1, while the acknowledge is still low. With this value, every status step of the disable, enable, domain-sleep, wakeup and abort sequences can be checked at an exact cycle.

// File: rtl/clkctl_pkg.sv
// Package: shared encodings and register layout of the module clock agent.
// Assumes a fixed 32-bit control word; field positions are behaviour.
package clkctl_pkg;

    typedef enum logic [1:0] {
        ST_FUNC  = 2'd0,
        ST_TRANS = 2'd1,
        ST_IDLE  = 2'd2,
        ST_DIS   = 2'd3
    } idle_st_e;

    localparam int          WORD_W     = 32;
    localparam logic [1:0]  MODE_DIS   = 2'd0;
    localparam logic [1:0]  MODE_EN    = 2'd2;
    localparam int          IDLEST_LSB = 16;
    localparam int          STBY_BIT   = 18;
    localparam int          OPTF_BIT   = 19;
    localparam logic [WORD_W-1:0] WORD_RESET = 32'h5258_0002;
    localparam logic [WORD_W-1:0] RW_MASK    = 32'h7FF8_0003;

endpackage

// File: rtl/clkctl_sync.sv
// Module: clkctl_sync
// Brings the asynchronous wakeup request into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 1; output is low during reset.
module clkctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_chain
            // Purpose: shift the request through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkctl_regs.sv
// Module: clkctl_regs
// Holds the control word and the effective mode, and assembles the read-back
// word. A reserved mode value is stored but leaves the effective mode alone.
// The module emits a one-cycle pulse when the effective mode changes.
module clkctl_regs
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  idle_st_e          idle_st,
    input  logic              mod_standby,
    output logic [WORD_W-1:0] rdata,
    output logic              eff_en,
    output logic              mode_chg,
    output logic              optf_bit
);
    logic [WORD_W-1:0] cfg_q;
    logic              eff_en_q;
    logic              chg_q;
    logic              stby_q;
    logic [1:0]        wmode;

    assign wmode = wdata[1:0];

    // Purpose: store writable bits and track the last valid mode selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= WORD_RESET & RW_MASK;
            eff_en_q <= 1'b1;
            chg_q    <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (we) begin
                cfg_q <= wdata & RW_MASK;
                if (wmode == MODE_DIS && eff_en_q) begin
                    eff_en_q <= 1'b0;
                    chg_q    <= 1'b1;
                end else if (wmode == MODE_EN && !eff_en_q) begin
                    eff_en_q <= 1'b1;
                    chg_q    <= 1'b1;
                end
            end
        end
    end

    // Purpose: sample the module standby indication for status read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) stby_q <= 1'b0;
        else        stby_q <= mod_standby;
    end

    // Purpose: merge stored fields with hardware status fields.
    always_comb begin
        rdata = cfg_q;
        rdata[IDLEST_LSB +: 2] = idle_st;
        rdata[STBY_BIT]        = stby_q;
    end

    assign eff_en   = eff_en_q;
    assign mode_chg = chg_q;
    assign optf_bit = cfg_q[OPTF_BIT];

    // R3: a reserved mode write never alters the effective mode.
    assert_reserved_mode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[0]) |=> $stable(eff_en_q));
endmodule

// File: rtl/clkctl_fsm.sv
// Module: clkctl_fsm
// Idle-status state machine and idle request. It assumes the module holds its
// acknowledge until the request is withdrawn. A mode change always re-enters
// the transition state.
module clkctl_fsm
    import clkctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     eff_en,
    input  logic     mode_chg,
    input  logic     dom_sleep_req,
    input  logic     wake_sync,
    input  logic     idle_ack,
    output logic     idle_req,
    output idle_st_e st
);
    idle_st_e st_q, st_d;

    // Purpose: request idle when disabled or when the domain sleeps, unless waking.
    always_comb begin
        idle_req = !wake_sync && (!eff_en || dom_sleep_req);
    end

    // Purpose: next-state selection for the idle status.
    always_comb begin
        st_d = st_q;
        if (mode_chg) begin
            st_d = ST_TRANS;
        end else begin
            case (st_q)
                ST_FUNC:  if (idle_req) st_d = ST_TRANS;
                ST_TRANS: begin
                    if (idle_req && idle_ack)        st_d = eff_en ? ST_IDLE : ST_DIS;
                    else if (!idle_req && !idle_ack) st_d = ST_FUNC;
                end
                ST_IDLE:  if (!idle_req) st_d = ST_TRANS;
                ST_DIS:   if (!idle_req) st_d = ST_TRANS;
                default:  st_d = ST_TRANS;
            endcase
        end
    end

    // Purpose: idle status register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FUNC;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R4: any effective mode change shows the transition status next.
    assert_chg_to_trans_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q == ST_TRANS));

    // R5: an acknowledged request settles into an idle state.
    assert_ack_settles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRANS && idle_req && idle_ack && !mode_chg) |=>
        (st_q == ST_IDLE || st_q == ST_DIS));

    // R6: idle states never jump straight to functional.
    assert_no_direct_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_DIS) |=> (st_q != ST_FUNC));

    // R9: a withdrawn, unacknowledged request returns to functional.
    assert_abort_to_func_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRANS && !idle_req && !idle_ack && !mode_chg) |=> (st_q == ST_FUNC));
endmodule

// File: rtl/clkctl_gate.sv
// Module: clkctl_gate
// Derives clock enables, sleep permit and access error from the idle status
// and effective mode. Purely combinational; clk/rst_n serve its checks.
module clkctl_gate
    import clkctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  idle_st_e st,
    input  logic     eff_en,
    input  logic     optf_bit,
    input  logic     bus_access,
    input  logic     bus_from_wakeup,
    output logic     iclk_en,
    output logic     fclk_en,
    output logic     optfclk_en,
    output logic     bus_err,
    output logic     sleep_permit
);
    logic fully_off;

    // Purpose: decode clock gating and domain-level outputs.
    always_comb begin
        fully_off    = (st == ST_DIS);
        iclk_en      = (st == ST_FUNC) || (st == ST_TRANS);
        fclk_en      = eff_en || !fully_off;
        optfclk_en   = optf_bit && !fully_off;
        sleep_permit = !eff_en && fully_off;
        bus_err      = bus_access && fully_off && !bus_from_wakeup;
    end

    // R7: enabled mode never lets the domain sleep.
    assert_no_permit_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eff_en |-> !sleep_permit);

    // R10: wakeup-originated accesses are never flagged.
    assert_wakeup_access_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_access && bus_from_wakeup) |-> !bus_err);

    // R5: a permitted sleep has all mandatory clocks stopped.
    assert_permit_clocks_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_permit |-> (!fclk_en && !iclk_en && !optfclk_en));
endmodule

// File: rtl/clkctl_agent.sv
// Module: clkctl_agent (top)
// Per-module clock control agent: control word, idle handshake FSM, wakeup
// synchroniser and clock gating decode. Assumes one clock and a synchronous
// active-low reset; the wakeup input may be asynchronous.
module clkctl_agent
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        mod_idle_ack,
    input  logic        mod_standby,
    input  logic        mod_wakeup_async,
    input  logic        dom_sleep_req,
    input  logic        bus_access,
    input  logic        bus_from_wakeup,
    output logic        iclk_en,
    output logic        fclk_en,
    output logic        optfclk_en,
    output logic        idle_req,
    output logic        bus_err,
    output logic        sleep_permit
);
    idle_st_e st;
    logic     eff_en, mode_chg, optf_bit, wake_sync;

    clkctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(mod_wakeup_async), .q_sync(wake_sync)
    );

    clkctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .idle_st(st), .mod_standby(mod_standby), .rdata(reg_rdata),
        .eff_en(eff_en), .mode_chg(mode_chg), .optf_bit(optf_bit)
    );

    clkctl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .eff_en(eff_en), .mode_chg(mode_chg),
        .dom_sleep_req(dom_sleep_req), .wake_sync(wake_sync),
        .idle_ack(mod_idle_ack), .idle_req(idle_req), .st(st)
    );

    clkctl_gate u_gate (
        .clk(clk), .rst_n(rst_n), .st(st), .eff_en(eff_en), .optf_bit(optf_bit),
        .bus_access(bus_access), .bus_from_wakeup(bus_from_wakeup),
        .iclk_en(iclk_en), .fclk_en(fclk_en), .optfclk_en(optfclk_en),
        .bus_err(bus_err), .sleep_permit(sleep_permit)
    );

    // R2: reserved bit positions never read as 1.
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] == 1'b0) && (reg_rdata[15:2] == 14'd0));
endmodule

// File: tb/clkctl_agent_bench.sv
// Directed bench for clkctl_agent: one task per scenario, inputs driven and
// outputs sampled on the falling edge.
module clkctl_agent_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mod_idle_ack = 1'b0, mod_standby = 1'b0, mod_wakeup_async = 1'b0;
    logic        dom_sleep_req = 1'b0, bus_access = 1'b0, bus_from_wakeup = 1'b0;
    logic        iclk_en, fclk_en, optfclk_en, idle_req, bus_err, sleep_permit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkctl_agent #(.SYNC_STAGES(2)) u_clkctl_agent (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mod_idle_ack(mod_idle_ack), .mod_standby(mod_standby),
        .mod_wakeup_async(mod_wakeup_async), .dom_sleep_req(dom_sleep_req),
        .bus_access(bus_access), .bus_from_wakeup(bus_from_wakeup),
        .iclk_en(iclk_en), .fclk_en(fclk_en), .optfclk_en(optfclk_en),
        .idle_req(idle_req), .bus_err(bus_err), .sleep_permit(sleep_permit)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        reg_we = 1'b1; reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset word", reg_rdata, 32'h5258_0002);
        chk("R1 reset clocks", {29'd0, iclk_en, fclk_en, optfclk_en}, 32'h7);
        chk("R7 reset permit", {31'd0, sleep_permit}, 32'd0);
    endtask

    task automatic t_disable();
        wr(32'h5258_0000);
        chk("R5 idle_req raised", {31'd0, idle_req}, 32'd1);
        step(1);
        chk("R4 status transition", {30'd0, reg_rdata[17:16]}, 32'd1);
        mod_idle_ack = 1'b1;
        step(1);
        chk("R5 status disabled", {30'd0, reg_rdata[17:16]}, 32'd3);
        chk("R5 clocks off", {29'd0, iclk_en, fclk_en, optfclk_en}, 32'd0);
        chk("R5 permit", {31'd0, sleep_permit}, 32'd1);
        bus_access = 1'b1;
        #1 chk("R10 error when disabled", {31'd0, bus_err}, 32'd1);
        bus_from_wakeup = 1'b1;
        #1 chk("R10 wakeup access ok", {31'd0, bus_err}, 32'd0);
        bus_access = 1'b0; bus_from_wakeup = 1'b0;
        #1 chk("R10 no access", {31'd0, bus_err}, 32'd0);
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FFFF);
        step(1);
        chk("R2 masking", reg_rdata, 32'h7FFB_0003);
        chk("R3 reserved keeps disabled", {31'd0, sleep_permit}, 32'd1);
        wr(32'h5258_0000);
        step(1);
        chk("R3 same mode no change", reg_rdata, 32'h525B_0000);
    endtask

    task automatic t_enable();
        wr(32'h5258_0002);
        chk("R6 idle_req dropped", {31'd0, idle_req}, 32'd0);
        chk("R7 no permit when enabled", {31'd0, sleep_permit}, 32'd0);
        step(1);
        chk("R6 status transition", {30'd0, reg_rdata[17:16]}, 32'd1);
        step(1);
        chk("R6 waits for ack release", {30'd0, reg_rdata[17:16]}, 32'd1);
        mod_idle_ack = 1'b0;
        step(1);
        chk("R6 functional", reg_rdata, 32'h5258_0002);
        chk("R6 clocks on", {29'd0, iclk_en, fclk_en, optfclk_en}, 32'h7);
    endtask

    task automatic t_sleep_wake();
        dom_sleep_req = 1'b1;
        #1 chk("R7 idle_req on sleep", {31'd0, idle_req}, 32'd1);
        step(1);
        chk("R7 status transition", {30'd0, reg_rdata[17:16]}, 32'd1);
        mod_idle_ack = 1'b1;
        step(1);
        chk("R7 status idle", {30'd0, reg_rdata[17:16]}, 32'd2);
        chk("R7 iclk off fclk on", {30'd0, iclk_en, fclk_en}, 32'd1);
        chk("R7 no permit in enabled", {31'd0, sleep_permit}, 32'd0);
        mod_wakeup_async = 1'b1;
        step(2);
        chk("R8 not before sync", {30'd0, reg_rdata[17:16]}, 32'd2);
        step(1);
        chk("R8 wake transition", {30'd0, reg_rdata[17:16]}, 32'd1);
        mod_idle_ack = 1'b0;
        step(1);
        chk("R8 functional", {30'd0, reg_rdata[17:16]}, 32'd0);
        mod_wakeup_async = 1'b0; dom_sleep_req = 1'b0;
        step(3);
        chk("R8 stays functional", {30'd0, reg_rdata[17:16]}, 32'd0);
    endtask

    task automatic t_abort();
        dom_sleep_req = 1'b1;
        step(1);
        chk("R9 transition", {30'd0, reg_rdata[17:16]}, 32'd1);
        mod_wakeup_async = 1'b1;
        for (int i = 0; i < 2; i++) begin
            step(1);
            chk("R9 holds transition", {30'd0, reg_rdata[17:16]}, 32'd1);
        end
        step(1);
        chk("R9 back to functional", {30'd0, reg_rdata[17:16]}, 32'd0);
        mod_wakeup_async = 1'b0; dom_sleep_req = 1'b0;
        step(3);
    endtask

    task automatic t_standby_optf();
        mod_standby = 1'b1;
        step(1);
        chk("R11 standby bit", {31'd0, reg_rdata[18]}, 32'd1);
        mod_standby = 1'b0;
        step(1);
        chk("R11 standby cleared", {31'd0, reg_rdata[18]}, 32'd0);
        wr(32'h5250_0002);
        chk("R12 optional clock off", {31'd0, optfclk_en}, 32'd0);
        chk("R12 fclk kept", {31'd0, fclk_en}, 32'd1);
        wr(32'h5258_0002);
        chk("R12 optional clock on", {31'd0, optfclk_en}, 32'd1);
        bus_access = 1'b1;
        #1 chk("R10 no error when enabled", {31'd0, bus_err}, 32'd0);
        bus_access = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disable();
        t_reserved();
        t_enable();
        t_sleep_wake();
        t_abort();
        t_standby_optf();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule